// File: doc/BRIEF.md
# Serial Control Register Receiver for a Stereo Audio Processor

This block is a write-only two-wire serial slave. It samples the clock and data lines with the system clock and finds start and stop conditions. It matches a fixed 7-bit device address and then loads five control registers that set up a stereo audio path: left volume, right volume, bass, treble and a switch register. The switch register holds mute, effect, stereo, mode and input-select bits.

A bus master opens each transfer with the device address and a write bit. It then sends a subaddress, which picks the first register, and one or more data bytes. Data bytes after the first go to the following registers in a fixed order. The block acknowledges each byte it accepts by pulling the data line low during the ninth clock. The decoded fields leave the block as parallel outputs that steer the analog stages. At reset the mute bit is set, so the audio output stays silent until the switch register is written.

Top module: `i2c_ctl_rx`

## Requirements
- R1: `busBusy` goes to 1 after a start condition, which is a falling SDA while SCL is high. It goes back to 0 after a stop condition, which is a rising SDA while SCL is high.
- R2: A start condition that arrives partway through a byte drops the partial byte, and the receiver expects a new address byte.
- R3: An address byte is acknowledged only when bits 7..1 equal `MOD_ADDR` and bit 0 (the read/write bit) is 0. After any other address byte, the block acknowledges nothing and writes no register until the next start condition.
- R4: The acknowledge pulls SDA low from the SCL fall that ends the eighth bit to the SCL fall that ends the ninth bit. SDA is released at all other times.
- R5: The second byte is a subaddress. 0x00 selects left volume, 0x01 right volume, 0x02 bass, 0x03 treble and 0x08 switch. Any other value is not acknowledged, and the bytes after it are dropped.
- R6: A volume data byte sets the 6-bit volume output from its bits 5..0. A bass or treble data byte sets the 4-bit output from its bits 3..0. The other bits of the byte are ignored.
- R7: A switch data byte sets `muteOn` from bit 5, `effectSel` from bit 4, `stereoSel` from bit 3, `modeSel` from bits 2..1 and `inputSel` from bit 0.
- R8: After reset, `muteOn` is 1. The volume, bass and treble outputs and all other switch outputs are 0.
- R9: Each acknowledged data byte moves the write target on in the order 0x00, 0x01, 0x02, 0x03, 0x08. Data bytes that arrive after the switch register has been written are not acknowledged and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaPullLow | output | 1 | 1 pulls SDA low (acknowledge) |
| busBusy | output | 1 | Bus is between a start and a stop |
| volLeft | output | 6 | Left volume code |
| volRight | output | 6 | Right volume code |
| bassCode | output | 4 | Bass code |
| trebleCode | output | 4 | Treble code |
| muteOn | output | 1 | Mute active |
| effectSel | output | 1 | Effect select bit |
| stereoSel | output | 1 | Stereo select bit |
| modeSel | output | 2 | Sound mode select |
| inputSel | output | 1 | Source input select |

## Verification
The assertions assume that SDA changes only while SCL is low, except at start and stop conditions. They also assume that each SCL level lasts many system clocks longer than the synchronizer delay, so the acknowledge is always switched while SCL is low. The bench master holds every SCL phase for at least five system clocks. It moves SDA only in the middle of the low phase, or in the middle of the high phase when it means to make a start or a stop. The bus the design sees is the wired-AND of the master's SDA and the block's pull-down.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int REG_COUNT = 5;
  localparam int PTR_W = 3;
  localparam logic [PTR_W-1:0] PTR_NONE = PTR_W'(REG_COUNT);

  typedef struct packed {
    logic       loadSub;
    logic       writeData;
    logic [7:0] rxByte;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IGNORE, ST_SHIFT, ST_ACKWAIT, ST_ACKDRIVE} rxState_t;
  typedef enum logic [1:0] {BK_ADDR, BK_SUB, BK_DATA} byteKind_t;

  // Map a subaddress to a register slot; PTR_NONE when undefined.
  function automatic logic [PTR_W-1:0] subIndex(input logic [7:0] sub);
    case (sub)
      8'h00:   return PTR_W'(0);
      8'h01:   return PTR_W'(1);
      8'h02:   return PTR_W'(2);
      8'h03:   return PTR_W'(3);
      8'h08:   return PTR_W'(4);
      default: return PTR_NONE;
    endcase
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    return (idx == 2 || idx == 3) ? 8'h0F : 8'h3F;
  endfunction

  function automatic logic [7:0] resetValue(input int idx);
    return (idx == REG_COUNT - 1) ? 8'h20 : 8'h00;
  endfunction
endpackage

// File: rtl/i2c_ctl_fsm.sv
module i2c_ctl_fsm
  import i2c_ctl_pkg::*;
#(
  parameter logic [6:0] MOD_ADDR = 7'h41,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       ptrValid,
  output ctlStrobe_t strobe,
  output logic       sdaPullLow,
  output logic       busBusy
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;
  rxState_t  state;
  byteKind_t kind;
  logic [2:0] bitCnt;
  logic [6:0] shiftReg;
  logic [7:0] newByte;
  logic byteDone, byteOk, ackFlag;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  assign sclRise   = sclS && !sclD;
  assign sclFall   = !sclS && sclD;
  assign startCond = sclS && sclD && sdaD && !sdaS;
  assign stopCond  = sclS && sclD && !sdaD && sdaS;
  assign newByte   = {shiftReg, sdaS};
  assign byteDone  = (state == ST_SHIFT) && sclRise && (bitCnt == 3'd7);

  always_comb begin
    case (kind)
      BK_ADDR: byteOk = (newByte[7:1] == MOD_ADDR) && !newByte[0];
      BK_SUB:  byteOk = (subIndex(newByte) != PTR_NONE);
      default: byteOk = ptrValid;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state      <= ST_IGNORE;
      kind       <= BK_ADDR;
      bitCnt     <= '0;
      shiftReg   <= '0;
      ackFlag    <= 1'b0;
      sdaPullLow <= 1'b0;
      busBusy    <= 1'b0;
      strobe     <= '0;
    end else begin
      strobe <= '0;
      if (startCond) begin
        state      <= ST_SHIFT;
        kind       <= BK_ADDR;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
        busBusy    <= 1'b1;
      end else if (stopCond) begin
        state      <= ST_IGNORE;
        sdaPullLow <= 1'b0;
        busBusy    <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: if (sclRise) begin
            shiftReg <= newByte[6:0];
            bitCnt   <= bitCnt + 3'd1;
            if (byteDone) begin
              state            <= ST_ACKWAIT;
              ackFlag          <= byteOk;
              strobe.rxByte    <= newByte;
              strobe.loadSub   <= (kind == BK_SUB) && byteOk;
              strobe.writeData <= (kind == BK_DATA) && byteOk;
            end
          end
          ST_ACKWAIT: if (sclFall) begin
            sdaPullLow <= ackFlag;
            state      <= ST_ACKDRIVE;
          end
          ST_ACKDRIVE: if (sclFall) begin
            sdaPullLow <= 1'b0;
            bitCnt     <= '0;
            if (ackFlag) begin
              state <= ST_SHIFT;
              kind  <= (kind == BK_ADDR) ? BK_SUB : BK_DATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end

  p_ack_on_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaPullLow) || $fell(sdaPullLow)) |-> !sclS);
  p_quiet_when_ignoring_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaPullLow);
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> busBusy);
  p_free_after_stop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stopCond && !startCond) |=> !busBusy);
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadSub, strobe.writeData}));
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  output logic       ptrValid,
  output logic [5:0] volLeft,
  output logic [5:0] volRight,
  output logic [3:0] bassCode,
  output logic [3:0] trebleCode,
  output logic       muteOn,
  output logic       effectSel,
  output logic       stereoSel,
  output logic [1:0] modeSel,
  output logic       inputSel
);
  logic [PTR_W-1:0] ptrIdx;
  logic [5:0] regQ [REG_COUNT];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 ptrIdx <= PTR_NONE;
    else if (strobe.loadSub)   ptrIdx <= subIndex(strobe.rxByte);
    else if (strobe.writeData) ptrIdx <= ptrIdx + PTR_W'(1);

  assign ptrValid = (ptrIdx < PTR_NONE);

  generate
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
      localparam logic [7:0] MASK = fieldMask(i);
      localparam logic [7:0] RSTV = resetValue(i);
      always_ff @(posedge clk or negedge rstN)
        if (!rstN)
          regQ[i] <= RSTV[5:0];
        else if (strobe.writeData && ptrIdx == PTR_W'(i))
          regQ[i] <= strobe.rxByte[5:0] & MASK[5:0];
    end
  endgenerate

  assign volLeft    = regQ[0];
  assign volRight   = regQ[1];
  assign bassCode   = regQ[2][3:0];
  assign trebleCode = regQ[3][3:0];
  assign muteOn     = regQ[4][5];
  assign effectSel  = regQ[4][4];
  assign stereoSel  = regQ[4][3];
  assign modeSel    = regQ[4][2:1];
  assign inputSel   = regQ[4][0];

  p_write_in_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeData |-> ptrValid);
  p_ptr_bounded_r9: assert property (@(posedge clk) disable iff (!rstN)
    ptrIdx <= PTR_NONE);
  p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeData |=> ($stable(volLeft) && $stable(volRight) &&
                           $stable(bassCode) && $stable(trebleCode)));
  p_switch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeData |=> ($stable(muteOn) && $stable(modeSel) && $stable(inputSel)));
endmodule

// File: rtl/i2c_ctl_rx.sv
module i2c_ctl_rx
  import i2c_ctl_pkg::*;
#(
  parameter logic [6:0] MOD_ADDR = 7'h41,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic       busBusy,
  output logic [5:0] volLeft,
  output logic [5:0] volRight,
  output logic [3:0] bassCode,
  output logic [3:0] trebleCode,
  output logic       muteOn,
  output logic       effectSel,
  output logic       stereoSel,
  output logic [1:0] modeSel,
  output logic       inputSel
);
  ctlStrobe_t strobe;
  logic ptrValid;

  i2c_ctl_fsm #(.MOD_ADDR(MOD_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ptrValid(ptrValid), .strobe(strobe),
    .sdaPullLow(sdaPullLow), .busBusy(busBusy)
  );

  i2c_ctl_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptrValid(ptrValid),
    .volLeft(volLeft), .volRight(volRight), .bassCode(bassCode),
    .trebleCode(trebleCode), .muteOn(muteOn), .effectSel(effectSel),
    .stereoSel(stereoSel), .modeSel(modeSel), .inputSel(inputSel)
  );
endmodule

// File: tb/i2c_ctl_rx_bench.sv
module i2c_ctl_rx_bench;
  localparam logic [6:0] MA = 7'h41;
  localparam logic [7:0] WR = {MA, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaBus;
  logic sdaPullLow, busBusy, muteOn, effectSel, stereoSel, inputSel;
  logic [5:0] volLeft, volRight;
  logic [3:0] bassCode, trebleCode;
  logic [1:0] modeSel;

  int compared = 0, mismatched = 0;
  bit settle = 1'b0, done = 1'b0;
  logic [7:0] refReg [5];
  logic [7:0] txQ [$];

  always #5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  i2c_ctl_rx #(.MOD_ADDR(MA)) u_i2c_ctl_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .busBusy(busBusy), .volLeft(volLeft),
    .volRight(volRight), .bassCode(bassCode), .trebleCode(trebleCode),
    .muteOn(muteOn), .effectSel(effectSel), .stereoSel(stereoSel),
    .modeSel(modeSel), .inputSel(inputSel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model of the register outputs, compared every cycle (R6, R7, R9).
  always @(negedge clk) begin
    if (rstN && !settle && !done) begin
      compared++;
      if (volLeft !== refReg[0][5:0] || volRight !== refReg[1][5:0] ||
          bassCode !== refReg[2][3:0] || trebleCode !== refReg[3][3:0]) begin
        mismatched++;
        $display("FAIL R6: actual %h %h %h %h expected %h %h %h %h", volLeft, volRight,
                 bassCode, trebleCode, refReg[0][5:0], refReg[1][5:0],
                 refReg[2][3:0], refReg[3][3:0]);
      end else if ({muteOn, effectSel, stereoSel, modeSel, inputSel} !== refReg[4][5:0]) begin
        mismatched++;
        $display("FAIL R7: actual %b expected %b",
                 {muteOn, effectSel, stereoSel, modeSel, inputSel}, refReg[4][5:0]);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int subSlot(input logic [7:0] s);
    case (s)
      8'h00: return 0;
      8'h01: return 1;
      8'h02: return 2;
      8'h03: return 3;
      8'h08: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic busStart();
    sdaM = 1'b1; cyc(5); sclM = 1'b1; cyc(10);
    sdaM = 1'b0; cyc(10); sclM = 1'b0; cyc(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; cyc(5); sclM = 1'b1; cyc(10);
    sdaM = 1'b1; cyc(15);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; cyc(5);
      if (i == 0) settle = 1'b1;
      sclM = 1'b1; cyc(10);
      sclM = 1'b0; cyc(5);
    end
    sdaM = 1'b1; cyc(5);
    sclM = 1'b1; cyc(5);
    acked = !sdaBus;
    cyc(5);
    sclM = 1'b0; cyc(5);
  endtask

  task automatic xfer(input bit glitch);
    int phase = 0;
    int ptr = 5;
    int idx;
    logic ack;
    bit expAck;
    string tag;
    busStart();
    chk(busBusy === 1'b1, "R1", busBusy, 1);
    if (glitch) begin
      for (int i = 3; i >= 0; i--) begin
        sdaM = i[0]; cyc(5); sclM = 1'b1; cyc(10); sclM = 1'b0; cyc(5);
      end
      busStart();
    end
    foreach (txQ[k]) begin
      idx = subSlot(txQ[k]);
      case (phase)
        0: begin expAck = (txQ[k][7:1] == MA) && !txQ[k][0]; tag = glitch ? "R2" : "R3"; end
        1: begin expAck = (idx < 5); tag = "R5"; end
        2: begin expAck = (ptr < 5); tag = "R9"; end
        default: begin expAck = 1'b0; tag = "R3"; end
      endcase
      sendByte(txQ[k], ack);
      chk(ack === expAck, tag, ack, expAck);
      chk(sdaPullLow === 1'b0, "R4", sdaPullLow, 0);
      if (phase == 2 && expAck) begin
        refReg[ptr] = txQ[k] & ((ptr == 2 || ptr == 3) ? 8'h0F : 8'h3F);
        ptr++;
      end
      if (!expAck) phase = 3;
      else if (phase == 0) phase = 1;
      else if (phase == 1) begin ptr = idx; phase = 2; end
      settle = 1'b0;
    end
    busStop();
    chk(busBusy === 1'b0, "R1", busBusy, 0);
  endtask

  initial begin
    refReg[0] = 8'h00; refReg[1] = 8'h00; refReg[2] = 8'h00;
    refReg[3] = 8'h00; refReg[4] = 8'h20;
    cyc(5);
    rstN = 1'b1;
    cyc(3);
    chk(muteOn === 1'b1, "R8", muteOn, 1);
    chk({volLeft, volRight, bassCode, trebleCode} === 20'h0, "R8",
        {volLeft, volRight, bassCode, trebleCode}, 0);
    chk(busBusy === 1'b0 && sdaPullLow === 1'b0, "R8", {busBusy, sdaPullLow}, 0);

    txQ = {WR, 8'h00, 8'hE5};                               xfer(1'b0);
    txQ = {WR, 8'h00, 8'hC1, 8'hFE, 8'hF9, 8'hF3, 8'hD6, 8'hFF}; xfer(1'b0);
    txQ = {WR, 8'h03, 8'hF5, 8'hE9};                        xfer(1'b0);
    txQ = {WR, 8'h05, 8'h11, 8'h22};                        xfer(1'b0);
    txQ = {{MA ^ 7'h01, 1'b0}, 8'h00, 8'h3F};               xfer(1'b0);
    txQ = {{MA, 1'b1}, 8'h00, 8'h3F};                       xfer(1'b0);
    txQ = {WR, 8'h01, 8'h2A};                               xfer(1'b1);
    txQ = {WR, 8'h08, 8'hFF, 8'h00};                        xfer(1'b0);
    txQ = {WR, 8'h02, 8'h07};                               xfer(1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule